// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial flash command at a time on a four-line data bus. A command is built from up to four fields, always in the same order: opcode, address, intermediate bytes (dummy or mode bytes), and data. A host presents a request with a one-cycle valid strobe. The request carries the opcode, the address, the length of each field, the bus width of each field, and whether data is written or read. While the command runs, the block drives chip select, the serial clock and the enable of each IO line.

Write data comes from a byte input. The block takes a byte at the start of each data byte and signals each take with a one-cycle pulse. Read data is assembled from the IO lines and returned as a byte with a one-cycle valid pulse. An implied-opcode option starts the command at the address field, which suits continuous-read modes. After chip select rises, the block stays busy for one serial clock period. This gives lines that were inputs time to return to output drive before a new command can start.

Top module: `qspi_cmd_seq`

## Requirements
- R1: The fields are sent in the order opcode, address, intermediate, data. The opcode is left out when `req_skip_op`=1. The address is left out when `req_addr_en`=0. The intermediate field is left out when its length is 0, and the data field is left out when its length is 0. A request with no field present is ignored: `busy` stays 0 and `spi_cs_n` stays 1.
- R2: `spi_cs_n` goes low on the clock edge that accepts a request. It stays low until the end of the last beat and is high at all other times.
- R3: `spi_sck` is low when idle and is never high while `spi_cs_n` is high. Each beat lasts 2×`sck_half` system cycles: first `sck_half` cycles low, then `sck_half` cycles high.
- R4: Bits are sent most-significant first. Single width uses IO0. Dual width uses IO1:IO0, with the earlier bit on IO1. Quad width uses IO3:IO0, with the earliest bit on IO3. The address field is 3 bytes (`req_addr[23:0]`) or 4 bytes (`req_addr4`=1), high byte first. Each intermediate byte carries `req_int_byte`.
- R5: The width code of each field is 0 for 1 line, 1 for 2 lines and 2 for 4 lines. Code 3 is treated as 1 line.
- R6: `io_oe` is 4'b0001 when idle, in single-width fields, and in single-width data fields in either direction. It is 4'b0011 in dual output fields and 4'b1111 in quad output fields. It is 4'b0000 in dual or quad input data fields. IO2 and IO3 are enabled only in quad fields.
- R7: After the last beat, `spi_cs_n` rises and `busy` stays 1 for 2×`sck_half` more cycles. If the last field was a dual or quad input field, `io_oe` stays 4'b0000 during that time and returns to 4'b0001 when `busy` falls. Otherwise `io_oe` is 4'b0001 during that time.
- R8: Input bits are sampled on the edge where `spi_sck` rises: IO1 in single width, IO1:IO0 in dual width, IO3:IO0 in quad width. `rd_valid` is high for one cycle, in the first high cycle of the last beat of each byte, with the byte on `rd_data`.
- R9: In a write data field, `wr_data` is captured at the start of each data byte. `wr_take` is high for one cycle, in the first cycle of that byte.
- R10: `busy` is 1 from acceptance until the turnaround ends. A `req_valid` raised while `busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_half | input | DIV_W | Half period of the serial clock in system cycles (0 treated as 1) |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_opcode | input | 8 | Opcode byte |
| req_skip_op | input | 1 | Implied opcode: leave out the opcode field |
| req_addr | input | 32 | Flash address |
| req_addr_en | input | 1 | Address field present |
| req_addr4 | input | 1 | 4-byte address (else 3) |
| req_int_len | input | 4 | Intermediate byte count |
| req_int_byte | input | 8 | Value sent in each intermediate byte |
| req_data_len | input | 16 | Data byte count |
| req_data_wr | input | 1 | 1 write data out, 0 read data in |
| req_w_op | input | 2 | Opcode field width code |
| req_w_addr | input | 2 | Address field width code |
| req_w_int | input | 2 | Intermediate field width code |
| req_w_data | input | 2 | Data field width code |
| busy | output | 1 | Command or turnaround in progress |
| wr_data | input | 8 | Next write byte |
| wr_take | output | 1 | Write byte taken |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte strobe |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| io_in | input | 4 | IO line input levels |
| io_out | output | 4 | IO line output levels |
| io_oe | output | 4 | IO line output enables |

## Verification
A new request can arrive while a transfer beat is active or while the turnaround is running. The bench provokes this by holding `req_valid` high with a different opcode for the first cycles of a command. Its cycle model predicts an unchanged waveform, so any restart or change of output is caught. The bench also compares the sampling of the last input beat, and its `rd_valid` pulse, against the clock low phase that ends the command. With a half period of one cycle these events fall on adjacent edges. The model checks the byte, the pulse cycle and the release of the lines together.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;

    localparam int OPC_W  = 8;
    localparam int ADDR_W = 32;
    localparam int INT_W  = 4;
    localparam int LEN_W  = 16;

    localparam logic [1:0] BW_1 = 2'd0;
    localparam logic [1:0] BW_2 = 2'd1;
    localparam logic [1:0] BW_4 = 2'd2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_XFER = 2'd1,
        PH_TURN = 2'd2
    } phase_e;

    // order of the values is the order of transmission
    typedef enum logic [1:0] {
        FLD_OP   = 2'd0,
        FLD_ADDR = 2'd1,
        FLD_INT  = 2'd2,
        FLD_DATA = 2'd3
    } field_e;

    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        logic             skip_op;
        logic             addr_en;
        logic             addr4;
        logic [INT_W-1:0] int_len;
        logic [7:0]       int_byte;
        logic [LEN_W-1:0] data_len;
        logic             data_wr;
        logic [1:0]       w_op;
        logic [1:0]       w_addr;
        logic [1:0]       w_int;
        logic [1:0]       w_data;
    } cmd_cfg_t;

    function automatic logic [1:0] norm_w(input logic [1:0] w);
        return (w == 2'd3) ? BW_1 : w;
    endfunction

endpackage

// File: rtl/qspi_sclk_gen.sv
module qspi_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim   = (half == '0) ? '0 : half - 1'b1;
        tick  = run && (cnt_q == lim);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: half period never overruns while running
    p_half_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= lim));

endmodule

// File: rtl/qspi_io_ctrl.sv
module qspi_io_ctrl
    import qspi_seq_pkg::*;
(
    input  phase_e     phase,
    input  logic [1:0] width,
    input  logic       in_field,
    input  logic       turn_hiz,
    input  logic [3:0] top_nib,
    output logic [3:0] oe,
    output logic [3:0] out
);
    always_comb begin
        oe  = 4'b0001;
        out = 4'b0000;
        if (phase == PH_TURN && turn_hiz) begin
            oe = 4'b0000;
        end else if (phase == PH_XFER) begin
            case (width)
                BW_2: begin
                    oe  = in_field ? 4'b0000 : 4'b0011;
                    out = {2'b00, top_nib[3:2]};
                end
                BW_4: begin
                    oe  = in_field ? 4'b0000 : 4'b1111;
                    out = top_nib;
                end
                default: begin
                    oe  = 4'b0001;
                    out = {3'b000, top_nib[3]};
                end
            endcase
        end
    end
endmodule

// File: rtl/qspi_cmd_seq.sv
module qspi_cmd_seq
    import qspi_seq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  sck_half,
    input  logic              req_valid,
    input  logic [OPC_W-1:0]  req_opcode,
    input  logic              req_skip_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_addr_en,
    input  logic              req_addr4,
    input  logic [INT_W-1:0]  req_int_len,
    input  logic [7:0]        req_int_byte,
    input  logic [LEN_W-1:0]  req_data_len,
    input  logic              req_data_wr,
    input  logic [1:0]        req_w_op,
    input  logic [1:0]        req_w_addr,
    input  logic [1:0]        req_w_int,
    input  logic [1:0]        req_w_data,
    output logic              busy,
    input  logic [7:0]        wr_data,
    output logic              wr_take,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              spi_cs_n,
    output logic              spi_sck,
    input  logic [3:0]        io_in,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe
);

    typedef struct packed {
        phase_e            phase;
        field_e            field;
        logic [1:0]        width;
        logic              in_field;
        logic [LEN_W-1:0]  bytes_left;
        logic [2:0]        beats_left;
        logic [7:0]        sr;
        logic [7:0]        rsr;
        logic [ADDR_W-1:0] addr;
        logic              sck;
        logic              cs_n;
        logic              turn_half;
        logic              turn_hiz;
        logic              rd_valid;
        logic [7:0]        rd_data;
        logic              wr_take;
        cmd_cfg_t          cfg;
    } st_t;

    st_t st_d, st_q;
    logic tick;

    // lowest present field at or after index 'from'; bit 2 flags a hit
    function automatic logic [2:0] next_fld(input logic [3:0] pres, input logic [2:0] from);
        logic [2:0] r;
        r = 3'b000;
        for (int i = 3; i >= 0; i--) begin
            if (pres[i] && (3'(i) >= from)) r = {1'b1, 2'(i)};
        end
        return r;
    endfunction

    function automatic logic [3:0] fields_of(input cmd_cfg_t c);
        return {c.data_len != '0, c.int_len != '0, c.addr_en, !c.skip_op};
    endfunction

    qspi_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.phase != PH_IDLE),
        .half  (sck_half),
        .tick  (tick)
    );

    qspi_io_ctrl u_io (
        .phase    (st_q.phase),
        .width    (st_q.width),
        .in_field (st_q.in_field),
        .turn_hiz (st_q.turn_hiz),
        .top_nib  (st_q.sr[7:4]),
        .oe       (io_oe),
        .out      (io_out)
    );

    cmd_cfg_t          cfg_in, cfg_src;
    logic [ADDR_W-1:0] addr_src;
    logic              accept;
    logic              do_load, ld_first;
    field_e            ld_field;
    logic [2:0]        nf;
    logic [7:0]        rsr_nx;
    logic [1:0]        ld_w;
    logic [LEN_W-1:0]  ld_cnt;

    always_comb begin
        cfg_in.opcode   = req_opcode;
        cfg_in.skip_op  = req_skip_op;
        cfg_in.addr_en  = req_addr_en;
        cfg_in.addr4    = req_addr4;
        cfg_in.int_len  = req_int_len;
        cfg_in.int_byte = req_int_byte;
        cfg_in.data_len = req_data_len;
        cfg_in.data_wr  = req_data_wr;
        cfg_in.w_op     = norm_w(req_w_op);
        cfg_in.w_addr   = norm_w(req_w_addr);
        cfg_in.w_int    = norm_w(req_w_int);
        cfg_in.w_data   = norm_w(req_w_data);

        accept   = (st_q.phase == PH_IDLE) && req_valid && (fields_of(cfg_in) != 4'b0000);
        cfg_src  = accept ? cfg_in : st_q.cfg;
        addr_src = accept ? (req_addr4 ? req_addr : {req_addr[23:0], 8'h00}) : st_q.addr;

        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.wr_take  = 1'b0;
        do_load       = 1'b0;
        ld_first      = 1'b0;
        ld_field      = FLD_OP;
        nf            = 3'b000;

        case (st_q.width)
            BW_2:    rsr_nx = {st_q.rsr[5:0], io_in[1:0]};
            BW_4:    rsr_nx = {st_q.rsr[3:0], io_in};
            default: rsr_nx = {st_q.rsr[6:0], io_in[1]};
        endcase

        case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    st_d.cfg   = cfg_in;
                    st_d.phase = PH_XFER;
                    st_d.cs_n  = 1'b0;
                    st_d.sck   = 1'b0;
                    st_d.addr  = addr_src;
                    nf         = next_fld(fields_of(cfg_in), 3'd0);
                    do_load    = 1'b1;
                    ld_first   = 1'b1;
                    ld_field   = field_e'(nf[1:0]);
                end
            end
            PH_XFER: begin
                if (tick) begin
                    if (!st_q.sck) begin
                        st_d.sck = 1'b1;
                        if (st_q.in_field) begin
                            st_d.rsr = rsr_nx;
                            if (st_q.beats_left == 3'd0) begin
                                st_d.rd_valid = 1'b1;
                                st_d.rd_data  = rsr_nx;
                            end
                        end
                    end else begin
                        st_d.sck = 1'b0;
                        if (st_q.beats_left != 3'd0) begin
                            st_d.beats_left = st_q.beats_left - 3'd1;
                            case (st_q.width)
                                BW_2:    st_d.sr = st_q.sr << 2;
                                BW_4:    st_d.sr = st_q.sr << 4;
                                default: st_d.sr = st_q.sr << 1;
                            endcase
                        end else if (st_q.bytes_left != '0) begin
                            do_load  = 1'b1;
                            ld_field = st_q.field;
                        end else begin
                            nf = next_fld(fields_of(st_q.cfg), {1'b0, st_q.field} + 3'd1);
                            if (nf[2]) begin
                                do_load  = 1'b1;
                                ld_first = 1'b1;
                                ld_field = field_e'(nf[1:0]);
                            end else begin
                                st_d.cs_n      = 1'b1;
                                st_d.phase     = PH_TURN;
                                st_d.turn_half = 1'b0;
                                st_d.turn_hiz  = st_q.in_field && (st_q.width != BW_1);
                            end
                        end
                    end
                end
            end
            PH_TURN: begin
                if (tick) begin
                    if (!st_q.turn_half) begin
                        st_d.turn_half = 1'b1;
                    end else begin
                        st_d.phase     = PH_IDLE;
                        st_d.turn_half = 1'b0;
                        st_d.turn_hiz  = 1'b0;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase

        // byte loader shared by every field
        case (ld_field)
            FLD_OP:   begin ld_w = cfg_src.w_op;   ld_cnt = LEN_W'(1); end
            FLD_ADDR: begin ld_w = cfg_src.w_addr; ld_cnt = cfg_src.addr4 ? LEN_W'(4) : LEN_W'(3); end
            FLD_INT:  begin ld_w = cfg_src.w_int;  ld_cnt = LEN_W'(cfg_src.int_len); end
            default:  begin ld_w = cfg_src.w_data; ld_cnt = cfg_src.data_len; end
        endcase

        if (do_load) begin
            st_d.field      = ld_field;
            st_d.width      = ld_w;
            st_d.in_field   = (ld_field == FLD_DATA) && !cfg_src.data_wr;
            st_d.bytes_left = ld_first ? ld_cnt - 1'b1 : st_q.bytes_left - 1'b1;
            case (ld_w)
                BW_2:    st_d.beats_left = 3'd3;
                BW_4:    st_d.beats_left = 3'd1;
                default: st_d.beats_left = 3'd7;
            endcase
            case (ld_field)
                FLD_OP:   st_d.sr = cfg_src.opcode;
                FLD_ADDR: begin
                    st_d.sr   = addr_src[ADDR_W-1 -: 8];
                    st_d.addr = addr_src << 8;
                end
                FLD_INT:  st_d.sr = cfg_src.int_byte;
                default: begin
                    st_d.sr      = cfg_src.data_wr ? wr_data : 8'h00;
                    st_d.wr_take = cfg_src.data_wr;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.phase != PH_IDLE);
    assign spi_cs_n = st_q.cs_n;
    assign spi_sck  = st_q.sck;
    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;
    assign wr_take  = st_q.wr_take;

    // R3: no clock activity with chip select released
    p_sck_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cs_n |-> !st_q.sck);
    // R2: a command only opens from the idle state
    p_cs_open_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.cs_n) |-> ($past(st_q.phase) == PH_IDLE));
    // R7: chip select rise always enters the turnaround
    p_turn_after_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.cs_n) |-> (st_q.phase == PH_TURN));
    // R8: read strobe lasts one cycle
    p_rd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rd_valid |=> !st_q.rd_valid);
    // R9: write takes only in write commands
    p_take_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_take |-> st_q.cfg.data_wr);
    // R6: idle enables
    p_idle_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (io_oe == 4'b0001));
    // R6: upper lines only in quad fields
    p_upper_quad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|io_oe[3:2]) |-> (st_q.width == BW_4));
    // R10: chip select low implies busy
    p_cs_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cs_n |-> busy);

endmodule

// File: tb/qspi_cmd_seq_tb.sv
module qspi_cmd_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sck_half = 8'd1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_opcode = '0;
    logic        req_skip_op = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_addr_en = 1'b0;
    logic        req_addr4 = 1'b0;
    logic [3:0]  req_int_len = '0;
    logic [7:0]  req_int_byte = '0;
    logic [15:0] req_data_len = '0;
    logic        req_data_wr = 1'b0;
    logic [1:0]  req_w_op = '0, req_w_addr = '0, req_w_int = '0, req_w_data = '0;
    logic        busy, wr_take, rd_valid, spi_cs_n, spi_sck;
    logic [7:0]  wr_data, rd_data;
    logic [3:0]  io_in = '0;
    logic [3:0]  io_out, io_oe;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int rd_idx = 0;

    always #10 clk = ~clk;

    qspi_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .sck_half(sck_half), .req_valid(req_valid),
        .req_opcode(req_opcode), .req_skip_op(req_skip_op), .req_addr(req_addr),
        .req_addr_en(req_addr_en), .req_addr4(req_addr4), .req_int_len(req_int_len),
        .req_int_byte(req_int_byte), .req_data_len(req_data_len), .req_data_wr(req_data_wr),
        .req_w_op(req_w_op), .req_w_addr(req_w_addr), .req_w_int(req_w_int),
        .req_w_data(req_w_data), .busy(busy), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
    );

    function automatic logic [7:0] wr_pat(input int k);
        return 8'hA5 ^ 8'(k * 37);
    endfunction
    function automatic logic [7:0] rd_pat(input int k);
        return 8'h3C + 8'(k * 29);
    endfunction

    always_comb wr_data = wr_pat(wr_cnt);
    always @(posedge clk) if (wr_take) wr_cnt <= wr_cnt + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural beat list of the expected waveform
    logic [3:0] q_out[$], q_oe[$], q_in[$];
    bit         q_take[$], q_rdv[$];
    logic [7:0] q_rdb[$];

    function automatic int wbits(input logic [1:0] w);
        return (w == 2'd1) ? 2 : (w == 2'd2) ? 4 : 1;
    endfunction

    task automatic add_byte(input logic [7:0] b, input logic [1:0] w, input bit is_in, input bit take);
        int n = wbits(w);
        for (int j = 0; j < 8 / n; j++) begin
            int chunk = (int'(b) >> (8 - n * (j + 1))) & ((1 << n) - 1);
            q_out.push_back(is_in ? 4'h0 : 4'(chunk));
            if (n == 1)      q_oe.push_back(4'b0001);
            else if (n == 2) q_oe.push_back(is_in ? 4'b0000 : 4'b0011);
            else             q_oe.push_back(is_in ? 4'b0000 : 4'b1111);
            q_in.push_back(!is_in ? 4'h0 : (n == 1) ? 4'(chunk << 1) : 4'(chunk));
            q_take.push_back(take && j == 0);
            q_rdv.push_back(is_in && j == 8 / n - 1);
            q_rdb.push_back(b);
        end
    endtask

    task automatic run_cmd(input int h, input bit hold);
        int          na, n;
        int          wbase = wr_cnt;
        logic [3:0]  turn_oe;
        q_out = {}; q_oe = {}; q_in = {}; q_take = {}; q_rdv = {}; q_rdb = {};
        if (!req_skip_op) add_byte(req_opcode, req_w_op, 0, 0);
        if (req_addr_en) begin
            na = req_addr4 ? 4 : 3;
            for (int i = 0; i < na; i++) add_byte(8'(req_addr >> (8 * (na - 1 - i))), req_w_addr, 0, 0);
        end
        for (int i = 0; i < int'(req_int_len); i++) add_byte(req_int_byte, req_w_int, 0, 0);
        for (int k = 0; k < int'(req_data_len); k++) begin
            if (req_data_wr) add_byte(wr_pat(wbase + k), req_w_data, 0, 1);
            else begin add_byte(rd_pat(rd_idx), req_w_data, 1, 0); rd_idx++; end
        end
        turn_oe = (req_data_len != 0 && !req_data_wr && (req_w_data == 2'd1 || req_w_data == 2'd2))
                  ? 4'b0000 : 4'b0001;
        n = q_out.size();
        sck_half = 8'(h);
        @(negedge clk);
        req_valid = 1'b1;
        @(posedge clk);
        for (int c = 0; c <= 2 * h * n + 2 * h; c++) begin
            @(negedge clk);
            if (c == 0 && !hold) req_valid = 1'b0;
            if (c == 0 && hold) req_opcode = ~req_opcode;
            if (c == 3) req_valid = 1'b0;
            if (c < 2 * h * n) begin
                int b = c / (2 * h);
                int ph = c % (2 * h);
                chk("R2 cs_n low in command", spi_cs_n, 0);
                chk("R3 sck phase", spi_sck, 32'(ph >= h));
                chk("R1 R4 R5 io_out beat", io_out, q_out[b]);
                chk("R6 io_oe beat", io_oe, q_oe[b]);
                chk("R9 wr_take", wr_take, 32'(q_take[b] && ph == 0));
                chk("R8 rd_valid", rd_valid, 32'(q_rdv[b] && ph == h));
                if (q_rdv[b] && ph == h) chk("R8 rd_data", rd_data, q_rdb[b]);
                chk("R10 busy in command", busy, 1);
                if (ph == 0) io_in = q_in[b];
            end else if (c < 2 * h * n + 2 * h) begin
                chk("R7 cs_n high in turnaround", spi_cs_n, 1);
                chk("R3 sck idle in turnaround", spi_sck, 0);
                chk("R7 io_oe in turnaround", io_oe, turn_oe);
                chk("R7 busy in turnaround", busy, 1);
            end else begin
                chk("R10 busy cleared", busy, 0);
                chk("R7 io_oe restored", io_oe, 4'b0001);
                chk("R2 cs_n idle", spi_cs_n, 1);
            end
        end
        io_in = 4'h0;
    endtask

    task automatic set_req(input logic [7:0] op, input bit skip, input logic [31:0] a,
                           input bit aen, input bit a4, input logic [3:0] il, input logic [7:0] ib,
                           input logic [15:0] dl, input bit wr,
                           input logic [1:0] wo, input logic [1:0] wa, input logic [1:0] wi,
                           input logic [1:0] wd);
        req_opcode = op; req_skip_op = skip; req_addr = a; req_addr_en = aen; req_addr4 = a4;
        req_int_len = il; req_int_byte = ib; req_data_len = dl; req_data_wr = wr;
        req_w_op = wo; req_w_addr = wa; req_w_int = wi; req_w_data = wd;
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset cs_n", spi_cs_n, 1);
        chk("R3 reset sck", spi_sck, 0);
        chk("R10 reset busy", busy, 0);
        chk("R6 reset io_oe", io_oe, 4'b0001);

        // R4 single-line read with 3-byte address
        set_req(8'h03, 0, 32'hFF12_3456, 1, 0, 4'd0, 8'h00, 16'd4, 0, 2'd0, 2'd0, 2'd0, 2'd0);
        run_cmd(2, 0);
        // R6 R8 quad read: 4-byte address, mode bytes, quad input
        set_req(8'hEC, 0, 32'h89AB_CDEF, 1, 1, 4'd3, 8'hA0, 16'd5, 0, 2'd0, 2'd2, 2'd2, 2'd2);
        run_cmd(1, 0);
        // R1 implied opcode quad read, R7 released lines in turnaround
        set_req(8'h00, 1, 32'h0000_1234, 1, 0, 4'd2, 8'h5A, 16'd3, 0, 2'd0, 2'd2, 2'd2, 2'd2);
        run_cmd(1, 0);
        // R9 dual write, width code 3 for opcode (R5)
        set_req(8'hA2, 0, 32'h00C0_FFEE, 1, 0, 4'd0, 8'h00, 16'd6, 1, 2'd3, 2'd1, 2'd0, 2'd1);
        run_cmd(3, 0);
        // R6 quad opcode and quad write
        set_req(8'h38, 0, 32'h1357_9BDF, 1, 1, 4'd1, 8'h77, 16'd4, 1, 2'd2, 2'd2, 2'd2, 2'd2);
        run_cmd(1, 0);
        // R1 opcode-only command
        set_req(8'h06, 0, 32'h0, 0, 0, 4'd0, 8'h00, 16'd0, 0, 2'd0, 2'd0, 2'd0, 2'd0);
        run_cmd(2, 0);
        // R10 dual read without address, request held while busy
        set_req(8'h9F, 0, 32'h0, 0, 0, 4'd1, 8'hFF, 16'd3, 0, 2'd0, 2'd0, 2'd0, 2'd1);
        run_cmd(1, 1);

        // R1 empty request is ignored
        set_req(8'h11, 1, 32'h0, 0, 0, 4'd0, 8'h00, 16'd0, 0, 2'd0, 2'd0, 2'd0, 2'd0);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        chk("R1 empty request busy", busy, 0);
        chk("R1 empty request cs_n", spi_cs_n, 1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1 empty request sck", spi_sck, 0);

        finish_run();
    end

endmodule